// File: doc/BRIEF.md
# Misaligned Operand Access Splitter

This block sits between a processor's load/store path and a 32-bit external bus port. It accepts one operand access at a time: an address, a size (byte, word or longword), a direction, a flag that marks an instruction fetch, and write data. Each access becomes the shortest sequence of bus transfers that never crosses a 32-bit line. The block presents one transfer and holds it until the slave acknowledges it, and only then moves to the next transfer.

Read bytes are gathered into an operand register in address order. A one-cycle completion pulse follows the final acknowledge. For writes, each transfer drives only the byte lanes it covers. An instruction fetch at an odd address is refused with an error pulse and causes no bus activity. There is no timeout: a transfer that is never acknowledged stays pending until an external abort input ends it.

Top module: `split_top`

## Requirements
- R1: A byte access at any offset is one byte transfer (bus_size 0) at its own address.
- R2: A longword at offset 0 is one longword transfer (bus_size 2). A word at offset 0, 1 or 2 is one word transfer (bus_size 1) at its own address.
- R3: A longword at offset 1 is carried out as three transfers in this order: a byte at offset 1, a word at offset 2, then a byte at offset 0 of the next line (address + 4 rounded down to a multiple of 4).
- R4: A longword at offset 2 is a word at offset 2, then a word at offset 0 of the next line. A longword at offset 3 is a byte at offset 3, then a word at offset 0 of the next line, then a byte at offset 2 of that line.
- R5: A word at offset 3 is a byte at offset 3, then a byte at offset 0 of the next line.
- R6: bus_req and every transfer field hold unchanged until bus_ack is sampled high. The next transfer appears in the cycle after that acknowledge, with no idle cycle between transfers.
- R7: Lanes are big-endian: byte offset i of the bus uses bus_rdata/bus_wdata bits [31-8i -: 8]. For reads, the operand is right-justified, with the lowest-addressed byte most significant. done pulses for one cycle, in the cycle after the final acknowledge, with the operand on rdata.
- R8: For writes, bus_be bit i is set only for the byte offsets i that the current transfer covers. Each covered lane carries the operand byte that belongs to that address, and uncovered lanes are zero.
- R9: A fetch (req_fetch=1) at an odd address gives a one-cycle addr_err pulse in the next cycle and no bus transfer. A fetch at an even address is split like a read.
- R10: bus_abort, sampled high while a transfer is pending, ends the access. The next cycle shows a one-cycle aborted pulse, no done, and bus_req low.
- R11: After reset the block is idle: req_ready is 1, and bus_req, done, addr_err and aborted are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Block idle, request accepted |
| req_addr | input | AW | Operand byte address |
| req_size | input | 2 | 0 byte, 1 word, 2 longword |
| req_write | input | 1 | 1 for store |
| req_fetch | input | 1 | 1 for instruction fetch |
| req_wdata | input | 32 | Store operand, right-justified |
| bus_req | output | 1 | Transfer pending |
| bus_addr | output | AW | Transfer byte address |
| bus_size | output | 2 | 0 byte, 1 word, 2 longword |
| bus_we | output | 1 | Transfer is a write |
| bus_be | output | 4 | Byte enables, bit i for offset i |
| bus_wdata | output | 32 | Write lanes |
| bus_ack | input | 1 | Transfer acknowledge |
| bus_rdata | input | 32 | Read lanes |
| bus_abort | input | 1 | Ends a pending access |
| done | output | 1 | Access complete pulse |
| rdata | output | 32 | Assembled read operand |
| addr_err | output | 1 | Misaligned fetch pulse |
| aborted | output | 1 | Access aborted pulse |

## Verification
The bench drives every size at all four offsets, and it targets the three-transfer longword orderings, where a design that swapped transfer order or forgot to move to the next line would put the wrong address or size on the bus. It varies the acknowledge delay. A design that advanced without an acknowledge, or inserted a dead cycle between transfers, would show a transfer one cycle off. Writes with crossing operands expose lane steering that puts an operand byte on the wrong lane or enables extra lanes. Odd fetches and a mid-sequence abort would show up as stray bus requests or a false done.

// File: rtl/split_pkg.sv
package split_pkg;
    localparam int DATA_W = 32;
    localparam int LANE_N = DATA_W / 8;
    localparam int OFF_W  = $clog2(LANE_N);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2
    } opsize_e;

    typedef enum logic {
        ST_IDLE,
        ST_BUSY
    } st_e;

    // one bus transfer: line select, lane offset, byte count, operand cursor
    typedef struct packed {
        logic             nxt;
        logic [OFF_W-1:0] off;
        logic [2:0]       len;
        logic [2:0]       cur;
    } xfer_t;

    function automatic xfer_t mk_xfer(logic nxt, logic [OFF_W-1:0] off,
                                      logic [2:0] len, logic [2:0] cur);
        xfer_t t;
        t.nxt = nxt;
        t.off = off;
        t.len = len;
        t.cur = cur;
        return t;
    endfunction
endpackage

// File: rtl/split_plan.sv
module split_plan
    import split_pkg::*;
(
    input  opsize_e          size,
    input  logic [OFF_W-1:0] off,
    input  logic [1:0]       step,
    output xfer_t            xf,
    output logic             last,
    output logic [2:0]       nbytes
);
    xfer_t      t0, t1, t2;
    logic [1:0] cnt;

    always_comb begin
        t0  = mk_xfer(1'b0, off, 3'd1, 3'd0);
        t1  = t0;
        t2  = t0;
        cnt = 2'd1;
        unique case (size)
            SZ_WORD: begin
                if (off == 2'd3) begin
                    cnt = 2'd2;
                    t0  = mk_xfer(1'b0, 2'd3, 3'd1, 3'd0);
                    t1  = mk_xfer(1'b1, 2'd0, 3'd1, 3'd1);
                end else begin
                    t0  = mk_xfer(1'b0, off, 3'd2, 3'd0);
                end
            end
            SZ_LONG: begin
                unique case (off)
                    2'd0: t0 = mk_xfer(1'b0, 2'd0, 3'd4, 3'd0);
                    2'd1: begin
                        cnt = 2'd3;
                        t0  = mk_xfer(1'b0, 2'd1, 3'd1, 3'd0);
                        t1  = mk_xfer(1'b0, 2'd2, 3'd2, 3'd1);
                        t2  = mk_xfer(1'b1, 2'd0, 3'd1, 3'd3);
                    end
                    2'd2: begin
                        cnt = 2'd2;
                        t0  = mk_xfer(1'b0, 2'd2, 3'd2, 3'd0);
                        t1  = mk_xfer(1'b1, 2'd0, 3'd2, 3'd2);
                    end
                    default: begin
                        cnt = 2'd3;
                        t0  = mk_xfer(1'b0, 2'd3, 3'd1, 3'd0);
                        t1  = mk_xfer(1'b1, 2'd0, 3'd2, 3'd1);
                        t2  = mk_xfer(1'b1, 2'd2, 3'd1, 3'd3);
                    end
                endcase
            end
            default: ;
        endcase
    end

    always_comb begin
        unique case (step)
            2'd1:    xf = t1;
            2'd2:    xf = t2;
            default: xf = t0;
        endcase
        last   = (step == cnt - 2'd1);
        nbytes = (size == SZ_LONG) ? 3'd4 : (size == SZ_WORD) ? 3'd2 : 3'd1;
    end
endmodule

// File: rtl/split_lanes.sv
module split_lanes
    import split_pkg::*;
(
    input  xfer_t             xf,
    input  logic [2:0]        nbytes,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [LANE_N-1:0] be,
    output logic [DATA_W-1:0] lanes_out,
    output logic [DATA_W-1:0] acc_out
);
    logic [LANE_N-1:0] hit;
    logic [1:0]        pos [LANE_N];

    // per lane: covered by this transfer, and operand byte position it maps to
    for (genvar l = 0; l < LANE_N; l++) begin : g_lane
        assign hit[l] = ({1'b0, xf.off} <= 3'(l)) && (3'(l) < {1'b0, xf.off} + xf.len);
        assign pos[l] = 2'(nbytes - 3'd1 - (xf.cur + 3'(l) - {1'b0, xf.off}));
    end

    always_comb begin
        be        = hit;
        lanes_out = '0;
        acc_out   = acc_in;
        for (int l = 0; l < LANE_N; l++) begin
            if (hit[l]) begin
                lanes_out[8*(LANE_N-1-l) +: 8] = wdata[8*pos[l] +: 8];
                acc_out[8*pos[l] +: 8]         = bus_rdata[8*(LANE_N-1-l) +: 8];
            end
        end
    end
endmodule

// File: rtl/split_top.sv
module split_top
    import split_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [AW-1:0]     req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic              req_fetch,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              bus_req,
    output logic [AW-1:0]     bus_addr,
    output logic [1:0]        bus_size,
    output logic              bus_we,
    output logic [LANE_N-1:0] bus_be,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_abort,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              addr_err,
    output logic              aborted
);
    localparam int LW = AW - OFF_W;

    typedef struct packed {
        st_e               st;
        opsize_e           size;
        logic              we;
        logic [LW-1:0]     line;
        logic [OFF_W-1:0]  off;
        logic [1:0]        step;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] acc;
        logic              done;
        logic              err;
        logic              abrt;
    } regs_t;

    regs_t             q, d;
    xfer_t             xf;
    logic              last;
    logic [2:0]        nbytes;
    logic [LANE_N-1:0] be;
    logic [DATA_W-1:0] lanes, acc_nx;

    split_plan u_plan (
        .size   (q.size),
        .off    (q.off),
        .step   (q.step),
        .xf     (xf),
        .last   (last),
        .nbytes (nbytes)
    );

    split_lanes u_lanes (
        .xf        (xf),
        .nbytes    (nbytes),
        .wdata     (q.wdata),
        .acc_in    (q.acc),
        .bus_rdata (bus_rdata),
        .be        (be),
        .lanes_out (lanes),
        .acc_out   (acc_nx)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        d.abrt = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_fetch && req_addr[0]) begin
                        d.err = 1'b1;
                    end else begin
                        d.st    = ST_BUSY;
                        d.size  = opsize_e'(req_size);
                        d.we    = req_write;
                        d.line  = req_addr[AW-1:OFF_W];
                        d.off   = req_addr[OFF_W-1:0];
                        d.step  = 2'd0;
                        d.wdata = req_wdata;
                        d.acc   = '0;
                    end
                end
            end
            default: begin
                if (bus_abort) begin
                    d.st   = ST_IDLE;
                    d.abrt = 1'b1;
                end else if (bus_ack) begin
                    if (!q.we) d.acc = acc_nx;
                    if (last) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.step = q.step + 2'd1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, size: SZ_BYTE, default: '0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        req_ready = (q.st == ST_IDLE);
        bus_req   = (q.st == ST_BUSY);
        bus_addr  = {q.line + LW'(xf.nxt), xf.off};
        bus_size  = (xf.len == 3'd4) ? 2'd2 : (xf.len == 3'd2) ? 2'd1 : 2'd0;
        bus_we    = bus_req && q.we;
        bus_be    = bus_req ? be : '0;
        bus_wdata = (bus_req && q.we) ? lanes : '0;
        done      = q.done;
        rdata     = q.acc;
        addr_err  = q.err;
        aborted   = q.abrt;
    end
endmodule

// File: rtl/split_chk.sv
module split_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_addr,
    input logic          req_fetch,
    input logic          bus_req,
    input logic [AW-1:0] bus_addr,
    input logic [1:0]    bus_size,
    input logic [3:0]    bus_be,
    input logic          bus_ack,
    input logic          bus_abort,
    input logic          done,
    input logic          addr_err,
    input logic          aborted
);
    // R6: a pending transfer holds until acknowledged or aborted
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack && !bus_abort |=> bus_req && $stable(bus_addr) && $stable(bus_size) && $stable(bus_be));

    // R9: odd fetch gives an error pulse and no transfer
    a_r9_err_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_fetch && req_addr[0] |=> addr_err && !bus_req);

    // R10: abort ends the access at once
    a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_abort |=> aborted && !bus_req && !done);

    // R7: completion only once the bus is quiet
    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bus_req);

    // R7, R9, R10: at most one outcome pulse per cycle
    a_r7_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, addr_err, aborted}));

    // R8: every transfer enables lanes, and never crosses the line
    a_r8_lanes_in_line: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> bus_be != 4'b0000 && !(bus_size == 2'd2 && bus_addr[1:0] != 2'd0)
                    && !(bus_size == 2'd1 && bus_addr[1:0] == 2'd3));
endmodule

bind split_top split_chk #(.AW(AW)) u_chk (.*);

// File: tb/split_top_bench.sv
module split_top_bench;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0, req_fetch = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = '0;
    logic [31:0]   req_wdata = '0;
    logic          req_ready, bus_req, bus_we, done, addr_err, aborted;
    logic [AW-1:0] bus_addr;
    logic [1:0]    bus_size;
    logic [3:0]    bus_be;
    logic [31:0]   bus_wdata, rdata;
    logic          bus_ack = 1'b0, bus_abort = 1'b0;
    logic [31:0]   bus_rdata = '0;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    split_top #(.AW(AW)) u_split_top (.*);

    typedef struct { int nxt; int off; int len; } tr_t;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mem(logic [AW-1:0] a);
        return (a[7:0] * 8'd7) ^ 8'hA5 ^ a[15:8];
    endfunction

    function automatic logic [31:0] line_data(logic [AW-1:0] a);
        logic [AW-1:0] b = {a[AW-1:2], 2'b00};
        return {mem(b), mem(b + 1), mem(b + 2), mem(b + 3)};
    endfunction

    task automatic run_op(string rq, logic [AW-1:0] addr, logic [1:0] sz,
                          logic wr, logic fe, logic [31:0] wd, int dly);
        tr_t q[$];
        int o = int'(addr[1:0]);
        int n = (sz == 2'd2) ? 4 : (sz == 2'd1) ? 2 : 1;
        logic [AW-1:0] base = {addr[AW-1:2], 2'b00};
        logic [31:0] er = '0;
        if (sz == 2'd0) q.push_back('{0, o, 1});
        else if (sz == 2'd1) begin
            if (o == 3) begin q.push_back('{0, 3, 1}); q.push_back('{1, 0, 1}); end
            else q.push_back('{0, o, 2});
        end else begin
            case (o)
                0: q.push_back('{0, 0, 4});
                1: begin q.push_back('{0, 1, 1}); q.push_back('{0, 2, 2}); q.push_back('{1, 0, 1}); end
                2: begin q.push_back('{0, 2, 2}); q.push_back('{1, 0, 2}); end
                default: begin q.push_back('{0, 3, 1}); q.push_back('{1, 0, 2}); q.push_back('{1, 2, 1}); end
            endcase
        end
        for (int j = 0; j < n; j++) er[8*(n-1-j) +: 8] = mem(addr + AW'(j));

        @(negedge clk);
        chk({rq, " R11 ready before request"}, req_ready, 1);
        req_valid = 1'b1; req_addr = addr; req_size = sz;
        req_write = wr; req_fetch = fe; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (fe && addr[0]) begin
            chk("R9 addr_err pulse", addr_err, 1);
            chk("R9 no transfer", bus_req, 0);
            @(negedge clk);
            chk("R9 addr_err one cycle", addr_err, 0);
            chk("R9 still no transfer", bus_req, 0);
            return;
        end
        foreach (q[k]) begin
            logic [AW-1:0] ta = base + AW'(4 * q[k].nxt + q[k].off);
            logic [3:0]    eb = '0;
            logic [31:0]   ew = '0;
            logic [1:0]    es = (q[k].len == 4) ? 2'd2 : (q[k].len == 2) ? 2'd1 : 2'd0;
            for (int l = q[k].off; l < q[k].off + q[k].len; l++) begin
                int j = 4 * q[k].nxt + l - o;
                eb[l] = 1'b1;
                if (wr) ew[8*(3-l) +: 8] = wd[8*(n-1-j) +: 8];
            end
            for (int w = 0; w <= dly; w++) begin
                chk({rq, " R6 bus_req"}, bus_req, 1);
                chk({rq, " addr"}, bus_addr, ta);
                chk({rq, " size"}, bus_size, es);
                chk({rq, " R8 be"}, bus_be, eb);
                chk({rq, " R8 we"}, bus_we, wr);
                chk({rq, " R8 wdata"}, bus_wdata, ew);
                chk({rq, " R7 no early done"}, done, 0);
                if (w == dly) begin
                    bus_ack = 1'b1;
                    bus_rdata = line_data(ta);
                end
                @(negedge clk);
                bus_ack = 1'b0;
                bus_rdata = '0;
            end
        end
        chk({rq, " R7 done pulse"}, done, 1);
        chk({rq, " R6 bus idle after last"}, bus_req, 0);
        if (!wr) chk({rq, " R7 rdata"}, rdata, er);
        @(negedge clk);
        chk({rq, " R7 done one cycle"}, done, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #5;
        chk("R11 reset ready", req_ready, 1);
        chk("R11 reset bus_req", bus_req, 0);
        chk("R11 reset done", done, 0);
        chk("R11 reset addr_err", addr_err, 0);
        chk("R11 reset aborted", aborted, 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        for (int o = 0; o < 4; o++) run_op("R1", 32'h0000_1200 + AW'(o), 2'd0, 1'b0, 1'b0, '0, o % 2);
        run_op("R2", 32'h0000_2000, 2'd2, 1'b0, 1'b0, '0, 0);
        for (int o = 0; o < 3; o++) run_op("R2", 32'h0000_2100 + AW'(o), 2'd1, 1'b0, 1'b0, '0, o);
        run_op("R3", 32'h0000_3001, 2'd2, 1'b0, 1'b0, '0, 0);
        run_op("R3", 32'h0000_30FD, 2'd2, 1'b0, 1'b0, '0, 2);
        run_op("R4", 32'h0000_4002, 2'd2, 1'b0, 1'b0, '0, 1);
        run_op("R4", 32'h0000_40FF, 2'd2, 1'b0, 1'b0, '0, 0);
        run_op("R5", 32'h0000_5003, 2'd1, 1'b0, 1'b0, '0, 3);
        run_op("R8", 32'h0000_6001, 2'd2, 1'b1, 1'b0, 32'h1122_3344, 0);
        run_op("R8", 32'h0000_6003, 2'd2, 1'b1, 1'b0, 32'hA1B2_C3D4, 1);
        run_op("R8", 32'h0000_6007, 2'd1, 1'b1, 1'b0, 32'h0000_BEEF, 0);
        run_op("R8", 32'h0000_6002, 2'd0, 1'b1, 1'b0, 32'h0000_005A, 2);
        run_op("R8", 32'h0000_6008, 2'd2, 1'b1, 1'b0, 32'hCAFE_F00D, 0);
        run_op("R9", 32'h0000_7003, 2'd1, 1'b0, 1'b1, '0, 0);
        run_op("R9", 32'h0000_7002, 2'd2, 1'b0, 1'b1, '0, 1);

        // R10: abort during the second transfer of a three-part longword
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h0000_8001; req_size = 2'd2;
        req_write = 1'b0; req_fetch = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 first transfer", bus_addr, 32'h0000_8001);
        bus_ack = 1'b1;
        @(negedge clk);
        bus_ack = 1'b0;
        chk("R10 second transfer", bus_addr, 32'h0000_8002);
        chk("R6 pending before abort", bus_req, 1);
        bus_abort = 1'b1;
        @(negedge clk);
        bus_abort = 1'b0;
        chk("R10 aborted pulse", aborted, 1);
        chk("R10 no done", done, 0);
        chk("R10 bus released", bus_req, 0);
        @(negedge clk);
        chk("R10 aborted one cycle", aborted, 0);
        chk("R10 ready again", req_ready, 1);

        run_op("R3", 32'h0000_9001, 2'd2, 1'b0, 1'b0, '0, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule